// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block works out the effective address of a load or store from a mode code, two register operands, the program counter, an immediate and a scale selector. It covers nine addressing forms: base only, base plus offset, base plus index, post-increment, pre-offset with update, scaled index with offset, program-counter relative, fixed address and pointer-through-memory. For the two update forms it also returns the new base value and a write enable, so the register file can update the base.

Eight of the forms produce a registered result one cycle after the request. The pointer-through-memory form sends one read to a simple memory port at the base address. The block stays busy until the response arrives, and the returned word becomes the final address one cycle later. The port is used for nothing else. The data access itself is left to the surrounding pipeline.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_valid`, `wb_en`, `mem_req` and `busy` are all low.
- R2: Mode code 0 (base only) gives `addr_out` = `base_val` with `addr_valid` high in the cycle after a request is accepted.
- R3: The immediate is sign-extended from bit 7 when `imm_size` is 0, from bit 15 when it is 1, and used as is when it is 2 or 3. Mode code 1 gives `base_val` plus the extended immediate.
- R4: Mode code 2 gives `base_val` + `index_val`.
- R5: Mode code 3 gives `addr_out` = `base_val`, with `wb_en` high and `wb_data` = `base_val` + 1 in the same cycle.
- R6: Mode code 4 gives `addr_out` = `base_val` + extended immediate, with `wb_en` high and `wb_data` equal to that same sum.
- R7: Mode code 5 gives `base_val` + `index_val` × 2^`scale_sel` + extended immediate, so the scale is 1, 2, 4 or 8.
- R8: Mode code 6 gives `pc_val` + extended immediate.
- R9: Mode code 8 gives the extended immediate alone, which is the same as zero plus the offset.
- R10: Mode code 7 behaves as follows. In the cycle after the request, `mem_req` is high for exactly one cycle with `mem_addr` = `base_val`, and `busy` goes high. `busy` stays high until the cycle in which `mem_rsp_valid` is sampled. In the next cycle, `addr_valid` is high with `addr_out` equal to the returned word, `busy` is low and `wb_en` is low.
- R11: All sums wrap modulo 2^32, and no overflow indication exists.
- R12: A request made while `busy` is high is ignored. A request with a reserved mode code (9 to 15) is ignored. An ignored request raises no `addr_valid`.
- R13: `wb_en` is high only for mode codes 3 and 4, and only in the cycle in which `addr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when not busy |
| mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| pc_val | input | 32 | Program counter of the instruction |
| imm_val | input | 32 | Immediate field, low bits significant |
| imm_size | input | 2 | Immediate width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| scale_sel | input | 2 | Index shift amount (scale 1, 2, 4, 8) |
| busy | output | 1 | Memory-indirect lookup in progress |
| addr_valid | output | 1 | Effective address valid this cycle |
| addr_out | output | 32 | Effective address |
| wb_en | output | 1 | Base-register writeback enable |
| wb_data | output | 32 | Base-register writeback value |
| mem_req | output | 1 | Pointer read request, one-cycle pulse |
| mem_addr | output | 32 | Pointer read address |
| mem_rsp_valid | input | 1 | Pointer read response strobe |
| mem_rsp_data | input | 32 | Returned pointer word |

## Verification
The hardest situation to reach is a second request that lands while a pointer lookup is still waiting for memory. The response has to be held off long enough for that request to arrive. The bench's memory responder therefore delays each reply by one to four cycles and issues a base-only request in every waiting cycle. It then checks that none of those requests produces a result, and that the address finally presented is the word read from the bench's memory array.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] imm_val,
  input  logic [1:0]    imm_size,
  input  logic [1:0]    scale_sel,
  output logic          busy,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);

  localparam logic [3:0] M_BASE  = 4'd0;
  localparam logic [3:0] M_DISP  = 4'd1;
  localparam logic [3:0] M_INDEX = 4'd2;
  localparam logic [3:0] M_POSTI = 4'd3;
  localparam logic [3:0] M_PREU  = 4'd4;
  localparam logic [3:0] M_SCALE = 4'd5;
  localparam logic [3:0] M_PCREL = 4'd6;
  localparam logic [3:0] M_PTR   = 4'd7;
  localparam logic [3:0] M_ABS   = 4'd8;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t state;

  logic [AW-1:0] simm, scaled_idx, calc_addr, calc_wb;
  logic          calc_wen, calc_ok;

  always_comb begin
    case (imm_size)
      2'd0:    simm = AW'($signed(imm_val[7:0]));
      2'd1:    simm = AW'($signed(imm_val[15:0]));
      default: simm = imm_val;
    endcase
  end

  assign scaled_idx = index_val << scale_sel;

  always_comb begin
    calc_addr = '0;
    calc_wb   = '0;
    calc_wen  = 1'b0;
    calc_ok   = 1'b1;
    case (mode)
      M_BASE:  calc_addr = base_val;
      M_DISP:  calc_addr = base_val + simm;
      M_INDEX: calc_addr = base_val + index_val;
      M_POSTI: begin
        calc_addr = base_val;
        calc_wb   = base_val + AW'(1);
        calc_wen  = 1'b1;
      end
      M_PREU: begin
        calc_addr = base_val + simm;
        calc_wb   = calc_addr;
        calc_wen  = 1'b1;
      end
      M_SCALE: calc_addr = base_val + scaled_idx + simm;
      M_PCREL: calc_addr = pc_val + simm;
      M_ABS:   calc_addr = simm;
      default: calc_ok = 1'b0;
    endcase
  end

  assign busy = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_valid <= 1'b0;
      addr_out   <= '0;
      wb_en      <= 1'b0;
      wb_data    <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      addr_valid <= 1'b0;
      wb_en      <= 1'b0;
      mem_req    <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (mode == M_PTR) begin
            state    <= S_WAIT;
            mem_req  <= 1'b1;
            mem_addr <= base_val;
          end else if (calc_ok) begin
            addr_valid <= 1'b1;
            addr_out   <= calc_addr;
            wb_en      <= calc_wen;
            wb_data    <= calc_wb;
          end
        end
        S_WAIT: if (mem_rsp_valid) begin
          state      <= S_IDLE;
          addr_valid <= 1'b1;
          addr_out   <= mem_rsp_data;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> addr_valid); // R13
  AST_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R10
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R10
  AST_PTR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid) |=> (addr_valid && !busy && !wb_en && addr_out == $past(mem_rsp_data))); // R10
  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) addr_valid |-> !busy); // R12
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rsp_valid) |=> (busy && !addr_valid)); // R12

endmodule

// File: tb/eff_addr_unit_tb_top.sv
module eff_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  mode;
  logic [31:0] base_val, index_val, pc_val, imm_val;
  logic [1:0]  imm_size, scale_sel;
  logic        busy, addr_valid, wb_en, mem_req, mem_rsp_valid;
  logic [31:0] addr_out, wb_data, mem_addr, mem_rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] memarr [16];

  always #10 clk = ~clk;

  eff_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_val(base_val), .index_val(index_val), .pc_val(pc_val),
    .imm_val(imm_val), .imm_size(imm_size), .scale_sel(scale_sel),
    .busy(busy), .addr_valid(addr_valid), .addr_out(addr_out),
    .wb_en(wb_en), .wb_data(wb_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_imm(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return v[7] ? {24'hFFFFFF, v[7:0]} : {24'h0, v[7:0]};
    if (sz == 2'd1) return v[15] ? {16'hFFFF, v[15:0]} : {16'h0, v[15:0]};
    return v;
  endfunction

  task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                       input logic [31:0] p, input logic [31:0] im,
                       input logic [1:0] isz, input logic [1:0] sc);
    req_valid = 1'b1; mode = m; base_val = b; index_val = x; pc_val = p;
    imm_val = im; imm_size = isz; scale_sel = sc;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_simple(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                            input logic [31:0] p, input logic [31:0] im,
                            input logic [1:0] isz, input logic [1:0] sc);
    logic [31:0] e, ea, ewb;
    logic ewen;
    logic ok;
    e = ext_imm(im, isz);
    ok = 1'b1; ewen = 1'b0; ewb = 32'h0; ea = 32'h0;
    case (m)
      4'd0: ea = b;                                  // R2
      4'd1: ea = b + e;                              // R3
      4'd2: ea = b + x;                              // R4
      4'd3: begin ea = b; ewen = 1'b1; ewb = b + 32'd1; end // R5
      4'd4: begin ea = b + e; ewen = 1'b1; ewb = b + e; end // R6
      4'd5: ea = b + x * (32'd1 << sc) + e;          // R7
      4'd6: ea = p + e;                              // R8
      4'd8: ea = e;                                  // R9
      default: ok = 1'b0;                            // R12
    endcase
    issue(m, b, x, p, im, isz, sc);
    if (!ok) begin
      chk("R12 reserved mode gives no valid", {31'h0, addr_valid}, 32'h0);
    end else begin
      chk($sformatf("R11 mode %0d valid", m), {31'h0, addr_valid}, 32'h1);
      chk($sformatf("R11 mode %0d addr", m), addr_out, ea);
      chk($sformatf("R13 mode %0d wb_en", m), {31'h0, wb_en}, {31'h0, ewen});
      if (ewen) chk($sformatf("R5/R6 mode %0d wb_data", m), wb_data, ewb);
    end
  endtask

  task automatic run_ptr(input logic [31:0] b, input int lat);
    logic [31:0] word;
    word = memarr[b[5:2]];
    issue(4'd7, b, 32'h0, 32'h0, 32'h0, 2'd2, 2'd0);
    chk("R10 mem_req pulse", {31'h0, mem_req}, 32'h1);
    chk("R10 mem_addr", mem_addr, b);
    chk("R10 busy set", {31'h0, busy}, 32'h1);
    chk("R10 no early valid", {31'h0, addr_valid}, 32'h0);
    for (int w = 0; w < lat - 1; w++) begin
      issue(4'd0, 32'hDEAD0000 + w, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0);
      chk("R12 request while busy ignored", {31'h0, addr_valid}, 32'h0);
      chk("R10 busy held", {31'h0, busy}, 32'h1);
      chk("R10 mem_req single", {31'h0, mem_req}, 32'h0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = word;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
    chk("R10 final valid", {31'h0, addr_valid}, 32'h1);
    chk("R10 final addr", addr_out, word);
    chk("R10 busy cleared", {31'h0, busy}, 32'h0);
    chk("R10 no writeback", {31'h0, wb_en}, 32'h0);
  endtask

  logic [31:0] vb [3] = '{32'h0000_1000, 32'hFFFF_FFF8, 32'h5555_AAAA};
  logic [31:0] vx [3] = '{32'h0000_0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
  logic [31:0] vp [3] = '{32'h0040_0000, 32'hFFFF_FFFC, 32'h0000_0008};
  logic [31:0] vi [3] = '{32'h0000_80F4, 32'h1234_5678, 32'hFFFF_7F81};

  initial begin
    for (int i = 0; i < 16; i++) memarr[i] = 32'h1000_0000 + i * 32'h0101_0040;
    rst_n = 1'b0; req_valid = 1'b0; mode = 4'd0; base_val = 0; index_val = 0;
    pc_val = 0; imm_val = 0; imm_size = 0; scale_sel = 0;
    mem_rsp_valid = 1'b0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'h0, addr_valid}, 32'h0);
    chk("R1 reset wb_en", {31'h0, wb_en}, 32'h0);
    chk("R1 reset mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1 reset busy", {31'h0, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", {31'h0, addr_valid}, 32'h0);
    chk("R1 after reset busy", {31'h0, busy}, 32'h0);
    for (int v = 0; v < 3; v++)
      for (int m = 0; m < 16; m++)
        if (m != 7)
          for (int s = 0; s < 4; s++)
            for (int c = 0; c < 4; c++)
              run_simple(4'(m), vb[v], vx[v], vp[v], vi[v], 2'(s), 2'(c));
    issue(4'd0, 32'h1, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0);
    @(negedge clk);
    chk("R2 valid lasts one cycle", {31'h0, addr_valid}, 32'h0);
    for (int l = 1; l <= 4; l++)
      for (int k = 0; k < 4; k++)
        run_ptr(32'h0000_0100 + 32'((k * 5 + l) * 4), l);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule